// File: doc/BRIEF.md
# Counter-Control Sequence Monitor

This block watches a stream of already-decoded bus events that concern one hardware counter and decides, event by event, whether the trace so far obeys a safety rule. The rule: the counter's control register may be rewritten only while the counter is stopped. An enable must be closed by a disable before any rewrite. A second enable before that disable is also outside the rule. Formally the accepted traces are the strings of `(enable disable | modify | disable)*`.

One event arrives per cycle as a 2-bit code with a valid strobe. The monitor holds a two-state automaton. State `ST_IDLE` means the counter is stopped and the trace so far is accepted. State `ST_ARMED` means an enable is still open, so the trace is a proper prefix of an accepted string. For every event the block emits a one-cycle verdict: pass (the trace is accepted), fail (the trace can no longer be accepted), or none (the trace is a neutral prefix). After a fail the automaton drops straight back to `ST_IDLE`, so a single fault yields a single fail pulse and monitoring resumes. A recovery unit downstream reacts to the pulses.

Transitions:
- `ST_IDLE` + modify or disable: stay in `ST_IDLE`, verdict pass.
- `ST_IDLE` + enable: go to `ST_ARMED`, verdict none.
- `ST_ARMED` + disable: go to `ST_IDLE`, verdict pass.
- `ST_ARMED` + modify or enable: go to `ST_IDLE`, verdict fail.

Top module: `ctrl_guard_monitor`

## Requirements
- R1: A synchronous active-high `rst` puts the automaton in `ST_IDLE` and drives `verdict` to 0. After reset, an open enable is forgotten, so a modify then gives pass.
- R2: In the cycle after a clock edge with `ev_valid` low, `verdict` is 0 and the automaton keeps its state. No verdict appears before the first event.
- R3: In `ST_IDLE`, a modify event (code 1) gives verdict 1 (pass) and the automaton stays in `ST_IDLE`.
- R4: In `ST_IDLE`, a disable event (code 0) gives verdict 1 (pass) and the automaton stays in `ST_IDLE`.
- R5: In `ST_IDLE`, an enable event (code 2) gives verdict 0 (neutral) and moves the automaton to `ST_ARMED`.
- R6: In `ST_ARMED`, a disable event gives verdict 1 and returns the automaton to `ST_IDLE`.
- R7: In `ST_ARMED`, a modify event gives verdict 2 (fail) and returns the automaton to `ST_IDLE` on the same event, so a following modify gives pass.
- R8: In `ST_ARMED`, a second enable event gives verdict 2 and returns the automaton to `ST_IDLE`.
- R9: Code 3 with `ev_valid` high is not an event: `verdict` is 0 in the next cycle and the state is unchanged.
- R10: A verdict appears in the cycle right after the accepted event and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | Event strobe for this cycle |
| ev_code | input | 2 | Event code: 0 disable, 1 modify, 2 enable, 3 unused |
| verdict | output | 2 | Registered verdict: 0 none, 1 pass, 2 fail |

## Verification
The bench goes after the points where the automaton could stick or repeat itself.

- **Fail followed by modify.** A monitor that parked in a dead state after a fail would report fail again on the next modify. The bench checks that this modify gives pass.
- **Idle cycles after a verdict.** A monitor that held its last verdict would repeat a pulse and fire a handler twice. The bench checks that `verdict` returns to 0.
- **Double enable.** A monitor built only from the modify rule would stay armed and miss the fail.
- **Unused code 3.** A monitor that treated code 3 as an event would emit a pulse or drop the open enable.
- **Reset while armed.** A monitor whose reset did not clear the open enable would turn a harmless modify into a fail.

// File: rtl/ctrl_guard_pkg.sv
package ctrl_guard_pkg;

    localparam int CODE_W = 2;
    localparam int VERD_W = 2;

    // raw event codes on the input
    localparam logic [CODE_W-1:0] CODE_DISABLE = 2'd0;
    localparam logic [CODE_W-1:0] CODE_MODIFY  = 2'd1;
    localparam logic [CODE_W-1:0] CODE_ENABLE  = 2'd2;

    typedef enum logic [1:0] {
        EVK_NONE    = 2'd0,
        EVK_DISABLE = 2'd1,
        EVK_MODIFY  = 2'd2,
        EVK_ENABLE  = 2'd3
    } evk_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } state_t;

    typedef enum logic [VERD_W-1:0] {
        VD_NONE = 2'd0,
        VD_PASS = 2'd1,
        VD_FAIL = 2'd2
    } verdict_t;

endpackage

// File: rtl/ctrl_guard_classify.sv
module ctrl_guard_classify
    import ctrl_guard_pkg::*;
(
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    output evk_t              kind_o
);

    always_comb begin
        kind_o = EVK_NONE;
        if (valid_i) begin
            unique case (code_i)
                CODE_DISABLE: kind_o = EVK_DISABLE;
                CODE_MODIFY:  kind_o = EVK_MODIFY;
                CODE_ENABLE:  kind_o = EVK_ENABLE;
                default:      kind_o = EVK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ctrl_guard_step.sv
module ctrl_guard_step
    import ctrl_guard_pkg::*;
(
    input  state_t   cur_i,
    input  evk_t     kind_i,
    output state_t   nxt_o,
    output verdict_t vd_o
);

    always_comb begin
        nxt_o = cur_i;
        vd_o  = VD_NONE;
        unique case (cur_i)
            ST_IDLE: begin
                unique case (kind_i)
                    EVK_ENABLE: begin
                        nxt_o = ST_ARMED;
                        vd_o  = VD_NONE;
                    end
                    EVK_MODIFY, EVK_DISABLE: begin
                        nxt_o = ST_IDLE;
                        vd_o  = VD_PASS;
                    end
                    default: ;
                endcase
            end
            ST_ARMED: begin
                unique case (kind_i)
                    EVK_DISABLE: begin
                        nxt_o = ST_IDLE;
                        vd_o  = VD_PASS;
                    end
                    // violation: report and restart in the same step
                    EVK_MODIFY, EVK_ENABLE: begin
                        nxt_o = ST_IDLE;
                        vd_o  = VD_FAIL;
                    end
                    default: ;
                endcase
            end
            default: begin
                nxt_o = ST_IDLE;
                vd_o  = VD_NONE;
            end
        endcase
    end

endmodule

// File: rtl/ctrl_guard_monitor.sv
module ctrl_guard_monitor
    import ctrl_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    output logic [VERD_W-1:0] verdict
);

    evk_t     kind;
    state_t   state_q;
    state_t   state_d;
    verdict_t vd_d;
    verdict_t vd_q;

    ctrl_guard_classify u_classify (
        .valid_i (ev_valid),
        .code_i  (ev_code),
        .kind_o  (kind)
    );

    ctrl_guard_step u_step (
        .cur_i  (state_q),
        .kind_i (kind),
        .nxt_o  (state_d),
        .vd_o   (vd_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // verdict register: a pulse only for the cycle after an event
    always_ff @(posedge clk) begin
        if (rst)                   vd_q <= VD_NONE;
        else if (kind == EVK_NONE) vd_q <= VD_NONE;
        else                       vd_q <= vd_d;
    end

    assign verdict = vd_q;

endmodule

// File: rtl/ctrl_guard_checker.sv
module ctrl_guard_checker
    import ctrl_guard_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ev_valid,
    input logic [CODE_W-1:0] ev_code,
    input logic [VERD_W-1:0] verdict,
    input state_t            state
);

    logic is_dis, is_mod, is_en;
    assign is_dis = ev_valid && (ev_code == CODE_DISABLE);
    assign is_mod = ev_valid && (ev_code == CODE_MODIFY);
    assign is_en  = ev_valid && (ev_code == CODE_ENABLE);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (verdict == 2'd0) && (state == ST_IDLE));

    assert_quiet_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        !ev_valid |=> (verdict == 2'd0) && $stable(state));

    assert_idle_modify_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && is_mod) |=> (verdict == 2'd1) && (state == ST_IDLE));

    assert_idle_disable_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && is_dis) |=> (verdict == 2'd1) && (state == ST_IDLE));

    assert_idle_enable_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && is_en) |=> (verdict == 2'd0) && (state == ST_ARMED));

    assert_armed_disable_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && is_dis) |=> (verdict == 2'd1) && (state == ST_IDLE));

    assert_armed_modify_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && is_mod) |=> (verdict == 2'd2) && (state == ST_IDLE));

    assert_armed_enable_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && is_en) |=> (verdict == 2'd2) && (state == ST_IDLE));

    assert_unused_code_R9: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_code == 2'd3) |=> (verdict == 2'd0) && $stable(state));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (verdict != 2'd0) |-> $past(ev_valid));

endmodule

bind ctrl_guard_monitor ctrl_guard_checker u_checker (
    .clk      (clk),
    .rst      (rst),
    .ev_valid (ev_valid),
    .ev_code  (ev_code),
    .verdict  (verdict),
    .state    (state_q)
);

// File: tb/tb_ctrl_guard_monitor.sv
module tb_ctrl_guard_monitor;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       ev_valid;
    logic [1:0] ev_code;
    logic [1:0] verdict;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural reference: is an enable currently open?
    bit open_enable = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ctrl_guard_monitor dut (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .ev_code  (ev_code),
        .verdict  (verdict)
    );

    task automatic check(input int got, input int exp, input string req);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: verdict got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int model(input bit v, input int c);
        int r = 0;
        if (!v || c == 3) return 0;
        if (!open_enable) begin
            if (c == 2) begin
                open_enable = 1;
                r = 0;
            end else begin
                r = 1;
            end
        end else begin
            open_enable = 0;
            r = (c == 0) ? 1 : 2;
        end
        return r;
    endfunction

    // drive at a falling edge, compare at the next falling edge
    task automatic step(input bit v, input int c, input string req);
        int exp;
        ev_valid = v;
        ev_code  = 2'(c);
        exp = model(v, c);
        @(negedge clk);
        check(int'(verdict), exp, req);
    endtask

    task automatic apply_reset(input string req);
        rst = 1'b1;
        ev_valid = 1'b0;
        open_enable = 0;
        repeat (2) @(negedge clk);
        check(int'(verdict), 0, req);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        ev_valid = 1'b0;
        ev_code = 2'd0;
        @(negedge clk);
        apply_reset("R1");
        step(0, 0, "R2");       // no verdict before first event
        step(1, 1, "R3");       // idle modify -> pass
        step(1, 0, "R4");       // idle disable -> pass
        step(0, 0, "R10");      // pulse gone
        step(1, 2, "R5");       // enable -> neutral
        step(0, 1, "R2");       // quiet while armed
        step(1, 0, "R6");       // disable closes -> pass
        step(1, 2, "R5");
        step(1, 1, "R7");       // modify while armed -> fail
        step(0, 0, "R10");      // fail pulse lasts one cycle
        step(1, 1, "R7");       // restarted: modify passes
        step(1, 2, "R5");
        step(1, 2, "R8");       // second enable -> fail
        step(1, 0, "R4");       // back in idle
        step(1, 3, "R9");       // unused code in idle
        step(1, 2, "R5");
        step(1, 3, "R9");       // unused code keeps the open enable
        step(1, 0, "R6");
        step(1, 2, "R5");
        step(1, 1, "R7");
        step(1, 1, "R3");
        step(1, 2, "R5");
        apply_reset("R1");      // reset while armed
        step(1, 1, "R1");       // open enable forgotten -> pass
        for (int i = 0; i < 40; i++) begin
            step(((i * 7) % 5) != 0, (i * 3 + i / 4) % 4, "R10");
        end
        step(0, 0, "R2");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule